// File: doc/BRIEF.md
# Inter-Processor Mailbox Register Bank

This block keeps a bank of 32-bit mailbox words that processor cores use to signal one another. Each core owns four mailboxes, sixteen in all with the default parameters. A sender raises bits in a receiver's mailbox by writing ones to that mailbox's set address. The receiver acknowledges by writing ones to the matching clear address. Zeros in the write data leave bits untouched in both cases, so several senders can share one word without a read-modify-write.

Each mailbox holds its interrupt for as long as any of its bits is one. Every core has a control word that enables each of its mailboxes as a normal interrupt (IRQ), as a fast interrupt (FIQ), or not at all. A mailbox with its fast enable set is reported only as FIQ. The per-mailbox IRQ and FIQ vectors are registered and passed to the interrupt aggregation logic outside this block. Access is through one synchronous read/write port with a registered read result.

Top module: `ipc_mailbox_bank`

## Requirements
- R1: While `rst` is high at a clock edge, every mailbox word and every control word clears to zero. After that edge `irq_vec`, `fiq_vec`, `rd_data` and `rd_valid` are zero.
- R2: A write to the word-aligned address 0x80 + 16*core + 4*mailbox ORs the write data into that mailbox.
- R3: A write to the word-aligned address 0xC0 + 16*core + 4*mailbox clears the mailbox bits where the write data is one and leaves the other bits unchanged.
- R4: A read of a set or clear address returns that mailbox's contents. `rd_data` and `rd_valid` appear one cycle after `rd_en`, and the read changes no mailbox. `rd_data` is zero in cycles with no read.
- R5: Core n's control word is at 0x50 + 4*n. Bits [3:0] enable mailboxes 0-3 as IRQ and bits [7:4] enable them as FIQ. A read returns these eight bits, and bits [31:8] read as zero.
- R6: `irq_vec[4*core+mailbox]` is high when the mailbox is nonzero, its IRQ enable is set and its FIQ enable is clear. It stays high while any bit remains set, including after a partial clear. The vector follows a state change one clock later.
- R7: When a nonzero mailbox has its FIQ enable set, `fiq_vec` is high for it and `irq_vec` is low for it, whatever its IRQ enable holds. The two vectors are never high for the same mailbox.
- R8: A nonzero mailbox whose two enables are both clear drives neither vector.
- R9: Writes to misaligned addresses (bits [1:0] nonzero) or to unmapped addresses change nothing. Reads of those addresses return zero.
- R10: When a read and a write reach the same mailbox in one cycle, the read returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | High the cycle after a read |
| irq_vec | output | 16 | Per-mailbox normal interrupt, index 4*core+mailbox |
| fiq_vec | output | 16 | Per-mailbox fast interrupt, index 4*core+mailbox |

## Verification
The hardest case to reach from the ports is a mailbox whose enables change while its contents are only partly cleared. Its interrupt has to move between the IRQ and FIQ vectors, or stay up, at exactly one clock of latency. The bench reaches this with directed sequences: partial clears on a mailbox that is still interrupting, and a control word rewritten while the mailbox holds data. A long random phase then mixes set, clear and control writes with reads to the same words. A behavioural model checks both vectors and the read port on every cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_CTRL = 2'd1,
    ACC_SET  = 2'd2,
    ACC_CLR  = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/mbx_addr_decode.sv
module mbx_addr_decode
  import mbx_pkg::*;
#(
  parameter int AW = 8,
  parameter int NCORE = 4,
  parameter int NMBX = 4,
  parameter logic [AW-1:0] CTRL_BASE = 8'h50,
  parameter logic [AW-1:0] SET_BASE  = 8'h80,
  parameter logic [AW-1:0] CLR_BASE  = 8'hC0,
  localparam int CORE_W = $clog2(NCORE),
  localparam int IDX_W  = $clog2(NCORE * NMBX)
) (
  input  logic [AW-1:0]     addr,
  output acc_kind_e         kind,
  output logic [IDX_W-1:0]  box_idx,
  output logic [CORE_W-1:0] core_idx
);
  // Windows are aligned to their own size, so a tag compare selects them.
  localparam int WIN_LSB  = IDX_W + 2;
  localparam int CTRL_LSB = CORE_W + 2;

  logic aligned;
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    kind = ACC_NONE;
    if (aligned) begin
      if (addr[AW-1:WIN_LSB] == SET_BASE[AW-1:WIN_LSB])
        kind = ACC_SET;
      else if (addr[AW-1:WIN_LSB] == CLR_BASE[AW-1:WIN_LSB])
        kind = ACC_CLR;
      else if (addr[AW-1:CTRL_LSB] == CTRL_BASE[AW-1:CTRL_LSB])
        kind = ACC_CTRL;
    end
  end

  assign box_idx  = addr[IDX_W+1:2];
  assign core_idx = addr[CORE_W+1:2];
endmodule

// File: rtl/mbx_bitmap_store.sv
module mbx_bitmap_store #(
  parameter int NENT = 16,
  parameter int DW = 32,
  localparam int IDX_W = $clog2(NENT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rd_word,
  output logic [NENT-1:0]  nz
);
  logic [DW-1:0] box [NENT];

  for (genvar i = 0; i < NENT; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)
        box[i] <= '0;
      else if (set_en && idx == IDX_W'(i))
        box[i] <= box[i] | wdata;
      else if (clr_en && idx == IDX_W'(i))
        box[i] <= box[i] & ~wdata;
    end

    assign nz[i] = |box[i];

    // R2: every bit written as one in a set access is present afterwards
    assert_set_bits_R2: assert property (@(posedge clk) disable iff (rst)
      ($past(set_en && !rst) && $past(idx) == IDX_W'(i))
        |-> ((box[i] & $past(wdata)) == $past(wdata)));

    // R3: every bit written as one in a clear access is gone afterwards
    assert_clr_bits_R3: assert property (@(posedge clk) disable iff (rst)
      ($past(clr_en && !rst) && $past(idx) == IDX_W'(i))
        |-> ((box[i] & $past(wdata)) == '0));

    // R4: with no mailbox write, the contents hold
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && !$past(set_en || clr_en)) |-> $stable(box[i]));
  end

  assign rd_word = box[idx];
endmodule

// File: rtl/mbx_irq_route.sv
module mbx_irq_route #(
  parameter int NCORE = 4,
  parameter int NMBX = 4,
  localparam int NENT = NCORE * NMBX,
  localparam int CORE_W = $clog2(NCORE),
  localparam int CTL_W = 2 * NMBX
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [CORE_W-1:0] ctl_sel,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic [NENT-1:0]   nz,
  output logic [CTL_W-1:0]  ctl_rdata,
  output logic [NENT-1:0]   irq_q,
  output logic [NENT-1:0]   fiq_q
);
  logic [CTL_W-1:0] ctl_r [NCORE];
  logic [NENT-1:0]  irq_d, fiq_d;

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    always_ff @(posedge clk) begin
      if (rst)
        ctl_r[c] <= '0;
      else if (ctl_we && ctl_sel == CORE_W'(c))
        ctl_r[c] <= ctl_wdata;
    end

    for (genvar m = 0; m < NMBX; m++) begin : g_box
      localparam int E = c * NMBX + m;
      logic ien, fen;
      assign ien = ctl_r[c][m];
      assign fen = ctl_r[c][NMBX + m];
      // The fast enable takes the mailbox away from the normal vector.
      assign fiq_d[E] = nz[E] & fen;
      assign irq_d[E] = nz[E] & ien & ~fen;

      // R6: a normal interrupt only follows a nonzero mailbox
      assert_irq_level_R6: assert property (@(posedge clk) disable iff (rst)
        irq_q[E] |-> $past(nz[E]));

      // R8: a fast interrupt only follows a nonzero mailbox
      assert_fiq_level_R8: assert property (@(posedge clk) disable iff (rst)
        fiq_q[E] |-> $past(nz[E]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= '0;
      fiq_q <= '0;
    end else begin
      irq_q <= irq_d;
      fiq_q <= fiq_d;
    end
  end

  assign ctl_rdata = ctl_r[ctl_sel];

  // R7: the two vectors never flag the same mailbox
  assert_fiq_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_q & fiq_q) == '0);
endmodule

// File: rtl/ipc_mailbox_bank.sv
module ipc_mailbox_bank
  import mbx_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int NCORE = 4,
  parameter int NMBX = 4,
  parameter logic [AW-1:0] CTRL_BASE = 8'h50,
  parameter logic [AW-1:0] SET_BASE  = 8'h80,
  parameter logic [AW-1:0] CLR_BASE  = 8'hC0,
  localparam int NENT = NCORE * NMBX
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rd_data,
  output logic            rd_valid,
  output logic [NENT-1:0] irq_vec,
  output logic [NENT-1:0] fiq_vec
);
  localparam int CORE_W = $clog2(NCORE);
  localparam int IDX_W  = $clog2(NENT);
  localparam int CTL_W  = 2 * NMBX;

  acc_kind_e         kind;
  logic [IDX_W-1:0]  box_idx;
  logic [CORE_W-1:0] core_idx;
  logic [DW-1:0]     box_word;
  logic [CTL_W-1:0]  ctl_word;
  logic [NENT-1:0]   nz;
  logic              set_en, clr_en, ctl_we;

  mbx_addr_decode #(
    .AW(AW), .NCORE(NCORE), .NMBX(NMBX),
    .CTRL_BASE(CTRL_BASE), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
  ) u_dec (
    .addr(addr), .kind(kind), .box_idx(box_idx), .core_idx(core_idx)
  );

  assign set_en = wr_en && (kind == ACC_SET);
  assign clr_en = wr_en && (kind == ACC_CLR);
  assign ctl_we = wr_en && (kind == ACC_CTRL);

  mbx_bitmap_store #(.NENT(NENT), .DW(DW)) u_store (
    .clk(clk), .rst(rst), .set_en(set_en), .clr_en(clr_en),
    .idx(box_idx), .wdata(wdata), .rd_word(box_word), .nz(nz)
  );

  mbx_irq_route #(.NCORE(NCORE), .NMBX(NMBX)) u_route (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_sel(core_idx),
    .ctl_wdata(wdata[CTL_W-1:0]), .nz(nz), .ctl_rdata(ctl_word),
    .irq_q(irq_vec), .fiq_q(fiq_vec)
  );

  // Read result is registered from the pre-write state of this cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= '0;
      if (rd_en) begin
        unique case (kind)
          ACC_SET, ACC_CLR: rd_data <= box_word;
          ACC_CTRL:         rd_data <= {{(DW-CTL_W){1'b0}}, ctl_word};
          default:          rd_data <= '0;
        endcase
      end
    end
  end

  // R1: the cycle after reset all outputs are quiet
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data == '0 && !rd_valid && irq_vec == '0 && fiq_vec == '0));

  // R9: a read of an unmapped or misaligned address returns zero
  assert_unmapped_read_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en && !rst) && $past(kind) == ACC_NONE) |-> (rd_data == '0));
endmodule

// File: tb/tb_ipc_mailbox_bank.sv
module tb_ipc_mailbox_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NENT = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [15:0] irq_vec, fiq_vec;

  int checks = 0;
  int errors = 0;

  ipc_mailbox_bank dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .rd_valid(rd_valid),
    .irq_vec(irq_vec), .fiq_vec(fiq_vec)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  logic [31:0] m_box [NENT];
  logic [7:0]  m_ctl [4];
  logic [15:0] e_irq = '0, e_fiq = '0;
  logic [31:0] e_rd = '0;
  logic        e_rv = 1'b0;

  function automatic int kind_of(input int a);  // 0 none,1 ctrl,2 set,3 clr
    if (a % 4 != 0) return 0;
    if (a >= 'h80 && a < 'hC0) return 2;
    if (a >= 'hC0 && a < 'h100) return 3;
    if (a >= 'h50 && a < 'h60) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_box[i]) m_box[i] = '0;
      foreach (m_ctl[i]) m_ctl[i] = '0;
      e_irq = '0; e_fiq = '0; e_rd = '0; e_rv = 1'b0;
    end else begin
      int a, k;
      a = int'(addr);
      k = kind_of(a);
      for (int e = 0; e < NENT; e++) begin
        bit busy, ie, fe;
        busy = (m_box[e] != 0);
        ie = m_ctl[e / 4][e % 4];
        fe = m_ctl[e / 4][4 + e % 4];
        e_fiq[e] = busy && fe;
        e_irq[e] = busy && ie && !fe;
      end
      e_rv = rd_en;
      e_rd = '0;
      if (rd_en) begin
        if (k == 2) e_rd = m_box[(a - 'h80) / 4];
        else if (k == 3) e_rd = m_box[(a - 'hC0) / 4];
        else if (k == 1) e_rd = {24'h0, m_ctl[(a - 'h50) / 4]};
      end
      if (wr_en) begin
        if (k == 2) m_box[(a - 'h80) / 4] = m_box[(a - 'h80) / 4] | wdata;
        else if (k == 3) m_box[(a - 'hC0) / 4] = m_box[(a - 'hC0) / 4] & ~wdata;
        else if (k == 1) m_ctl[(a - 'h50) / 4] = wdata[7:0];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R6 irq_vec model", {16'h0, irq_vec}, {16'h0, e_irq});
      chk("R7 fiq_vec model", {16'h0, fiq_vec}, {16'h0, e_fiq});
      chk("R4 rd_valid model", {31'h0, rd_valid}, {31'h0, e_rv});
      chk("R4 rd_data model", rd_data, e_rd);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    d = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 irq after reset", {16'h0, irq_vec}, 32'h0);
    chk("R1 fiq after reset", {16'h0, fiq_vec}, 32'h0);
    chk("R1 rd_data after reset", rd_data, 32'h0);
    rd(8'h50, v); chk("R1 ctrl0 after reset", v, 32'h0);
    rd(8'hBC, v); chk("R1 mailbox after reset", v, 32'h0);

    // R2/R6: set, level interrupt
    wr(8'h50, 32'h01);
    wr(8'h80, 32'h5);
    idle(1);
    chk("R6 irq mb0 core0 set", {31'h0, irq_vec[0]}, 32'h1);
    rd(8'h80, v); chk("R2 set readback", v, 32'h5);
    rd(8'hC0, v); chk("R4 read via clear addr", v, 32'h5);
    wr(8'h80, 32'h10);
    rd(8'h80, v); chk("R2 set ORs bits", v, 32'h15);

    // R3/R6: partial clear keeps interrupt, full clear drops it
    wr(8'hC0, 32'h4);
    rd(8'h80, v); chk("R3 partial clear", v, 32'h11);
    chk("R6 irq held after partial clear", {31'h0, irq_vec[0]}, 32'h1);
    wr(8'hC0, 32'h11);
    idle(1);
    chk("R6 irq dropped when empty", {31'h0, irq_vec[0]}, 32'h0);

    // R7/R5: fast enable wins; control readback
    wr(8'hAC, 32'h8000_0000);
    wr(8'h58, 32'h88);
    idle(1);
    chk("R7 fiq core2 mb3", {31'h0, fiq_vec[11]}, 32'h1);
    chk("R7 irq suppressed core2 mb3", {31'h0, irq_vec[11]}, 32'h0);
    rd(8'h58, v); chk("R5 ctrl readback", v, 32'h88);
    wr(8'h58, 32'hFFFF_FF08);
    rd(8'h58, v); chk("R5 upper ctrl bits read zero", v, 32'h08);
    chk("R6 irq after fast enable removed", {31'h0, irq_vec[11]}, 32'h1);
    chk("R7 fiq cleared", {31'h0, fiq_vec[11]}, 32'h0);

    // R8: disabled mailbox stays silent
    wr(8'h94, 32'h1);
    wr(8'h54, 32'h0);
    idle(1);
    chk("R8 irq masked core1 mb1", {31'h0, irq_vec[5]}, 32'h0);
    chk("R8 fiq masked core1 mb1", {31'h0, fiq_vec[5]}, 32'h0);
    rd(8'h94, v); chk("R8 masked mailbox still holds data", v, 32'h1);

    // R9: misaligned and unmapped accesses
    wr(8'h81, 32'hFFFF_FFFF);
    rd(8'h80, v); chk("R9 misaligned set ignored", v, 32'h0);
    wr(8'hC5, 32'hFFFF_FFFF);
    rd(8'h84, v); chk("R9 misaligned clear ignored", v, 32'h0);
    wr(8'h60, 32'hFF);
    rd(8'h60, v); chk("R9 unmapped read zero", v, 32'h0);
    wr(8'h4C, 32'hFF);
    rd(8'h5C, v); chk("R9 unmapped write left ctrl3", v, 32'h0);
    rd(8'h82, v); chk("R9 misaligned read zero", v, 32'h0);

    // R10: read and write in one cycle
    rd_en = 1'b1; wr_en = 1'b1; addr = 8'h84; wdata = 32'h3;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    chk("R10 read returns pre-write value", rd_data, 32'h0);
    rd(8'h84, v); chk("R10 write took effect", v, 32'h3);

    // Random phase, checked by the model every cycle
    for (int n = 0; n < 3000; n++) begin
      int sel;
      sel = $urandom_range(0, 9);
      wr_en = ($urandom_range(0, 2) != 0);
      rd_en = ($urandom_range(0, 1) != 0);
      if (sel < 4)      addr = 8'h80 + 8'($urandom_range(0, 15) * 4);
      else if (sel < 7) addr = 8'hC0 + 8'($urandom_range(0, 15) * 4);
      else if (sel < 9) addr = 8'h50 + 8'($urandom_range(0, 3) * 4);
      else              addr = 8'($urandom_range(0, 255));
      wdata = (sel < 4) ? (32'h1 << $urandom_range(0, 31)) : $urandom();
      @(negedge clk);
    end
    wr_en = 1'b0; rd_en = 1'b0;
    idle(2);

    // R1: reset in mid-operation clears everything
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 irq after second reset", {16'h0, irq_vec}, 32'h0);
    chk("R1 fiq after second reset", {16'h0, fiq_vec}, 32'h0);
    @(negedge clk);
    rd(8'h80, v); chk("R1 mailbox cleared by reset", v, 32'h0);
    summary();
  end
endmodule